// File: doc/BRIEF.md
# Cascaded Up/Down Loadable Counter

A 12-bit synchronous binary counter assembled from three identical 4-bit slices. A ripple-carry chain joins the slices. The enable input feeds the carry-in of the lowest slice. Each slice passes a carry to the next slice only when it is itself counting and sits at its terminal value: all ones when counting up, all zeros when counting down. An upper slice therefore moves only when every slice below it has reached its end value.

The counter can load a 12-bit word at any time through an active-low synchronous load. It can then hold that word, or count up or down from it. A combinational terminal carry at the top of the chain marks the end of a count. To time an interval, load a value N. Counting down, the carry rises after N clock periods. Counting up, it rises after 4095 − N clock periods. The individual count bits also serve as divided clocks.

Top module: `cascade_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `count` becomes 0. This takes priority over load, enable and direction.
- R2: When `rst_n` is high and `load_n` is low at a rising edge, `count` takes the value of `load_val`, whatever `cnt_en` and `dir_down` are.
- R3: When `load_n` is high and `cnt_en` is low, `count` keeps its value across the edge.
- R4: When `load_n` is high, `cnt_en` is high and `dir_down` is 0, `count` increases by one at each edge. Counting from 0x0FF gives 0x100, so the carry crosses slice boundaries.
- R5: When `load_n` is high, `cnt_en` is high and `dir_down` is 1, `count` decreases by one at each edge. Counting from 0x100 gives 0x0FF.
- R6: Counting wraps from 0xFFF to 0x000 going up and from 0x000 to 0xFFF going down.
- R7: `carry_out` is high exactly when `load_n` is high, `cnt_en` is high, and `count` is either 0xFFF with `dir_down` = 0 or 0x000 with `dir_down` = 1. It depends combinationally on these inputs and is low during a load.
- R8: After loading N and then enabling the count, `carry_out` first rises after N edges when counting down and after 4095 − N edges when counting up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low clear |
| load_n | input | 1 | Synchronous active-low parallel load |
| load_val | input | 12 | Word captured on load |
| cnt_en | input | 1 | Count enable, drives the lowest slice's carry-in |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| count | output | 12 | Present count value |
| carry_out | output | 1 | Terminal carry from the top slice |

## Verification
The bench uses the default parameters: three slices of four bits each. With these values the full 4096-value range can be reached in a few thousand cycles. Both wrap points and both slice-boundary crossings are covered by the vector table. Two interval runs, one down from 295 and one up from 4000, check the carry timing against the preset value.

// File: rtl/cascade_counter_pkg.sv
// Shared definitions for the cascaded counter.
// Assumes: direction encoding 0 = up, 1 = down is fixed at the ports.
package cascade_counter_pkg;

    // Count direction encoding as seen on dir_down
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } count_dir_e;

    // Width of one slice unless overridden
    localparam int unsigned DEFAULT_SLICE_W = 4;

endpackage

// File: rtl/slice_terminal.sv
// Terminal-value detector for one counter slice.
// Flags all-ones when counting up and all-zeros when counting down.
// Assumes: purely combinational, no clock.
module slice_terminal #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] q,
    input  logic         dir_down,
    output logic         at_end
);
    import cascade_counter_pkg::*;

    localparam logic [W-1:0] ALL_ONES  = '1;
    localparam logic [W-1:0] ALL_ZEROS = '0;

    // Pick the end value that matches the direction
    always_comb begin
        if (count_dir_e'(dir_down) == DIR_DOWN) at_end = (q == ALL_ZEROS);
        else                                     at_end = (q == ALL_ONES);
    end
endmodule

// File: rtl/count_slice.sv
// One W-bit counter slice with synchronous clear, load, hold and up/down count.
// Counts only while carry_in is high. Passes a carry when it is counting
// and at its terminal value.
// Assumes: clear beats load, and load beats counting.
module count_slice #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] load_val,
    input  logic         carry_in,
    input  logic         dir_down,
    output logic [W-1:0] q,
    output logic         carry_out
);
    localparam logic [W-1:0] STEP = W'(1);

    logic at_end;

    slice_terminal #(.W(W)) u_term (
        .q        (q),
        .dir_down (dir_down),
        .at_end   (at_end)
    );

    // Next-state register: clear, load, count or hold
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (!load_n)  q <= load_val;
        else if (carry_in) q <= dir_down ? (q - STEP) : (q + STEP);
    end

    // Ripple carry to the next slice
    always_comb carry_out = carry_in & at_end;
endmodule

// File: rtl/cascade_counter.sv
// Top level: NUM_SLICES counter slices chained by a ripple carry.
// cnt_en feeds the lowest carry-in. The top carry, masked during a load,
// is the terminal event.
// Assumes: all control inputs are synchronous to clk.
module cascade_counter #(
    parameter int unsigned SLICE_W    = 4,
    parameter int unsigned NUM_SLICES = 3,
    localparam int unsigned TOTAL_W   = SLICE_W * NUM_SLICES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic [TOTAL_W-1:0] load_val,
    input  logic               cnt_en,
    input  logic               dir_down,
    output logic [TOTAL_W-1:0] count,
    output logic               carry_out
);
    logic [NUM_SLICES:0] chain;

    // Enable is the carry into the least significant slice
    always_comb chain[0] = cnt_en;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        count_slice #(.W(SLICE_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_n    (load_n),
            .load_val  (load_val[s*SLICE_W +: SLICE_W]),
            .carry_in  (chain[s]),
            .dir_down  (dir_down),
            .q         (count[s*SLICE_W +: SLICE_W]),
            .carry_out (chain[s+1])
        );
    end

    // Terminal carry, suppressed while a load is requested
    always_comb carry_out = chain[NUM_SLICES] & load_n;
endmodule

// File: rtl/cascade_counter_props.sv
// Property checker for cascade_counter, attached with bind below.
// Assumes: observes ports only; reset is synchronous active-low.
module cascade_counter_props #(
    parameter int unsigned TOTAL_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_n,
    input logic [TOTAL_W-1:0] load_val,
    input logic               cnt_en,
    input logic               dir_down,
    input logic [TOTAL_W-1:0] count,
    input logic               carry_out
);
    localparam logic [TOTAL_W-1:0] ONE  = TOTAL_W'(1);
    localparam logic [TOTAL_W-1:0] TOPV = '1;

    assert_clear_R1: assert property (@(posedge clk)
        !rst_n |=> count == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(load_val));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en) |=> $stable(count));

    assert_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && !dir_down) |=> count == $past(count) + ONE);

    assert_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && dir_down) |=> count == $past(count) - ONE);

    assert_no_carry_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !carry_out);

    assert_carry_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (cnt_en && (dir_down ? (count == '0) : (count == TOPV))));
endmodule

bind cascade_counter cascade_counter_props #(.TOTAL_W(TOTAL_W)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .load_val  (load_val),
    .cnt_en    (cnt_en),
    .dir_down  (dir_down),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/cascade_counter_test.sv
// Self-checking bench: vector table first, then interval runs.
module cascade_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;
    localparam int NVEC = 14;

    logic         clk = 1'b0;
    logic         rst_n, load_n, cnt_en, dir_down;
    logic [W-1:0] load_val;
    logic [W-1:0] count;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    cascade_counter uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
        .cnt_en(cnt_en), .dir_down(dir_down), .count(count), .carry_out(carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {rst_n, load_n, en, dir, din[11:0], exp_count[11:0], exp_carry_before_edge}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0,1'b0,1'b1,1'b0,12'hABC,12'h000,1'b0}, // R1 clear beats load
        {1'b1,1'b0,1'b0,1'b0,12'h0FE,12'h0FE,1'b0}, // R2 load with enable low
        {1'b1,1'b1,1'b1,1'b0,12'h000,12'h0FF,1'b0}, // R4 up
        {1'b1,1'b1,1'b1,1'b0,12'h000,12'h100,1'b0}, // R4 slice crossing up
        {1'b1,1'b1,1'b1,1'b1,12'h000,12'h0FF,1'b0}, // R5 slice crossing down
        {1'b1,1'b1,1'b0,1'b1,12'h000,12'h0FF,1'b0}, // R3 hold
        {1'b1,1'b0,1'b1,1'b1,12'hFFF,12'hFFF,1'b0}, // R2 load while counting down
        {1'b1,1'b1,1'b1,1'b0,12'h000,12'h000,1'b1}, // R6 wrap up, R7 carry
        {1'b1,1'b1,1'b1,1'b1,12'h000,12'hFFF,1'b1}, // R6 wrap down, R7 carry
        {1'b1,1'b1,1'b0,1'b0,12'h000,12'hFFF,1'b0}, // R3 hold, R7 no carry when disabled
        {1'b1,1'b0,1'b1,1'b1,12'h001,12'h001,1'b0}, // R2 load
        {1'b1,1'b1,1'b1,1'b1,12'h000,12'h000,1'b0}, // R5 down to zero
        {1'b0,1'b0,1'b1,1'b1,12'h555,12'h000,1'b0}, // R1 clear priority, R7 no carry on load
        {1'b1,1'b1,1'b1,1'b0,12'h000,12'h001,1'b0}  // R4 up from zero
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs an enabled count from preset n and returns the edges until carry rises
    task automatic interval(input logic dn, input logic [W-1:0] n, output int edges);
        load_n = 1'b0; load_val = n; cnt_en = 1'b1; dir_down = dn;
        @(posedge clk); @(negedge clk);
        load_n = 1'b1;
        edges = 0;
        #1;
        while (!carry_out && edges < 5000) begin
            @(posedge clk); @(negedge clk); #1;
            edges++;
        end
    endtask

    initial begin
        rst_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; dir_down = 1'b0; load_val = '0;
        @(posedge clk); @(negedge clk);
        check("R1 reset state", count, 12'h000);
        check("R7 no carry at reset", {11'b0, carry_out}, 12'h000);

        for (int i = 0; i < NVEC; i++) begin
            {rst_n, load_n, cnt_en, dir_down, load_val} = VEC[i][28:13];
            #1;
            check($sformatf("R7 carry vec %0d", i), {11'b0, carry_out}, {11'b0, VEC[i][0]});
            @(posedge clk); @(negedge clk);
            check($sformatf("R1-R6 count vec %0d", i), count, VEC[i][12:1]);
        end

        begin
            int e;
            interval(1'b1, 12'd295, e);
            check("R8 down interval", W'(e), 12'd295);
            interval(1'b0, 12'd4000, e);
            check("R8 up interval", W'(e), 12'd95);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule